// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter

This block is a free-running 16-bit up-counter for an 8-bit peripheral bus. A control register picks what drives it: nothing (counter stopped), the bus clock on every cycle, a fixed-rate enable pulse, or rising edges seen on an external pin. The selected enables then pass through a power-of-two prescaler before they advance the counter, which wraps from 0xFFFF to 0x0000.

Software reads the count one byte at a time. Reading either byte captures the whole 16-bit value into a holding buffer. Later reads return bytes from that buffer until the other byte has been read, so the two bytes always belong to the same count, whichever byte is read first. Writes to either counter byte or to the control register return the holding buffer to idle. A write to the high byte also clears the counter.

Top module: `tmr_counter16`

## Requirements
- R1: After reset the counter is 0x0000, the control register is 0x00 (clock select 00, prescale 000), the read buffer is idle and rdata_o is 0x00.
- R2: Address 1 reads the high counter byte and address 2 reads the low byte. When the buffer is idle, a read of either byte captures all 16 counter bits and returns its byte from that capture. While the buffer is held, reads of either byte return bytes of the captured value. The first read of the byte other than the one that started the capture releases the buffer.
- R3: Any write to address 0, 1 or 2 returns the read buffer to idle, so the next counter read captures a fresh value.
- R4: Any write to address 1 clears the counter and the prescaler. A write to address 2 leaves the counter unchanged.
- R5: Control bits [4:3] select the count source: 00 none (counter holds), 01 every bus clock cycle, 10 each cycle with fix_en_i high, 11 each rising edge of ext_clk_i.
- R6: Control bits [2:0] = p divide the selected source by 2^p. The counter advances once per 2^p source enables.
- R7: ext_clk_i passes through two synchronizer flops and an edge detector. A high level first sampled at clock edge k after a sampled low counts as one source enable at edge k+2. The pin must change at no more than one quarter of the bus clock frequency.
- R8: A control write whose bits [4:0] differ from the current value clears the prescaler, and the counter does not advance on that cycle. A control write of the same value leaves the prescaler running.
- R9: The counter wraps from 0xFFFF to 0x0000.
- R10: A read presents its data on rdata_o from the clock edge that samples rd_i. rdata_o holds its value until the next read. Address 0 reads {3'b000, select, prescale}, and address 3 reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fix_en_i | input | 1 | Fixed-rate count enable, synchronous to clk_i |
| ext_clk_i | input | 1 | External count pin, asynchronous |
| addr_i | input | 2 | Register address: 0 control, 1 count high, 2 count low |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe, never asserted with rd_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |

## Verification
The bench reads the counter in high-then-low order, in low-then-high order, with repeated reads of one byte, and with a write placed inside a held pair. These orderings separate a correct buffer from one that never releases, releases on the wrong byte, or ignores writes. Each source is run separately: the bus clock under all eight prescale codes, an irregular fix_en_i pattern, and the external pin at two toggle rates. This shows whether the divide ratio, the enable gating and the synchronizer delay are each right. A long run at divide 1 crosses 0xFFFF to show the wrap. Control rewrites with the same value and with a new value show whether the prescaler is cleared only when the setting changes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned PS_W = 3;

  typedef enum logic [1:0] {
    CS_OFF = 2'b00,
    CS_BUS = 2'b01,
    CS_FIX = 2'b10,
    CS_EXT = 2'b11
  } clk_sel_e;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_CNT_HI = 2'd1,
    A_CNT_LO = 2'd2,
    A_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= (i == 0) ? pin_i : sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  AST_EXT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R7
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            clr_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] pcnt_q;
  logic [DIV_W-1:0] lim;
  logic             at_lim;

  assign lim    = ~({DIV_W{1'b1}} << ps_i);
  assign at_lim = (pcnt_q == lim);
  assign tick_o = en_i & at_lim & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pcnt_q <= '0;
    else if (clr_i) pcnt_q <= '0;
    else if (en_i)  pcnt_q <= at_lim ? '0 : pcnt_q + 1'b1;
  end

  AST_PRESC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= lim); // R6
  AST_PRESC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pcnt_q == '0); // R8
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0); // R4
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + W'(1))); // R9
endmodule

// File: rtl/tmr_counter16.sv
module tmr_counter16
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fix_en_i,
  input  logic       ext_clk_i,
  input  logic [1:0] addr_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = CNT_W / 2;
  localparam int unsigned CTL_W  = 2 + PS_W;

  clk_sel_e        cs_q;
  logic [PS_W-1:0] ps_q;
  logic            ext_rise, src_en, tick;
  logic [CNT_W-1:0] cnt, buf_q;
  logic            lat_q, first_hi_q;
  logic            ctrl_wr, hi_wr, lo_wr, any_wr, sel_chg;
  logic            rd_hi, rd_lo;
  logic [7:0]      rdata_q;

  assign ctrl_wr = wr_i && (addr_i == A_CTRL);
  assign hi_wr   = wr_i && (addr_i == A_CNT_HI);
  assign lo_wr   = wr_i && (addr_i == A_CNT_LO);
  assign any_wr  = ctrl_wr | hi_wr | lo_wr;
  assign sel_chg = ctrl_wr && (wdata_i[CTL_W-1:0] != {cs_q, ps_q});
  assign rd_hi   = rd_i && (addr_i == A_CNT_HI);
  assign rd_lo   = rd_i && (addr_i == A_CNT_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= CS_OFF;
      ps_q <= '0;
    end else if (ctrl_wr) begin
      cs_q <= clk_sel_e'(wdata_i[CTL_W-1:PS_W]);
      ps_q <= wdata_i[PS_W-1:0];
    end
  end

  tmr_ext_sync #(.SYNC_STAGES(2)) i_ext_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (ext_clk_i),
    .rise_o(ext_rise)
  );

  always_comb begin
    unique case (cs_q)
      CS_BUS:  src_en = 1'b1;
      CS_FIX:  src_en = fix_en_i;
      CS_EXT:  src_en = ext_rise;
      default: src_en = 1'b0;
    endcase
  end

  tmr_prescaler #(.PS_W(PS_W)) i_prescaler (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (src_en),
    .clr_i (hi_wr | sel_chg),
    .ps_i  (ps_q),
    .tick_o(tick)
  );

  tmr_count #(.W(CNT_W)) i_count (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (hi_wr),
    .inc_i (tick),
    .cnt_o (cnt)
  );

  // read path with coherency buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q    <= '0;
      buf_q      <= '0;
      lat_q      <= 1'b0;
      first_hi_q <= 1'b0;
    end else if (any_wr) begin
      lat_q <= 1'b0;
    end else if (rd_hi || rd_lo) begin
      if (!lat_q) begin
        buf_q      <= cnt;
        lat_q      <= 1'b1;
        first_hi_q <= rd_hi;
        rdata_q    <= rd_hi ? cnt[CNT_W-1:BYTE_W] : cnt[BYTE_W-1:0];
      end else begin
        rdata_q <= rd_hi ? buf_q[CNT_W-1:BYTE_W] : buf_q[BYTE_W-1:0];
        if (rd_hi != first_hi_q) lat_q <= 1'b0;
      end
    end else if (rd_i) begin
      rdata_q <= (addr_i == A_CTRL) ? 8'({cs_q, ps_q}) : 8'h00;
    end
  end

  assign rdata_o = rdata_q;

  AST_LATCH_IDLE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_wr |=> !lat_q); // R3
  AST_RD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_hi || rd_lo) && !lat_q) |=> lat_q && (buf_q == $past(cnt))); // R2
  AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q |=> $stable(buf_q)); // R2
  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_q == CS_OFF && !hi_wr) |=> $stable(cnt)); // R5
  AST_NO_RD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i)); // R10
endmodule

// File: tb/test_tmr_counter16.sv
module test_tmr_counter16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fix_en = 1'b0;
  logic       ext_clk = 1'b0;
  logic [1:0] addr = '0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";
  bit fix_mode = 0;
  int ext_half = 0;
  int pat = 0;

  // reference state
  int m_cnt, m_div, m_cs, m_ps, m_buf, m_rdata;
  bit m_lat, m_first_hi;
  bit m_e1, m_e2, m_e3;

  always #10 clk = ~clk;

  tmr_counter16 i_tmr_counter16 (
    .clk_i(clk), .rst_ni(rst_n), .fix_en_i(fix_en), .ext_clk_i(ext_clk),
    .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural model, evaluated on pre-edge values
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_div = 0; m_cs = 0; m_ps = 0; m_buf = 0; m_rdata = 0;
      m_lat = 0; m_first_hi = 0; m_e1 = 0; m_e2 = 0; m_e3 = 0;
    end else begin
      int old_cnt;
      bit rise, en;
      old_cnt = m_cnt;
      rise = m_e2 && !m_e3;
      m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_clk;
      case (m_cs)
        1: en = 1;
        2: en = fix_en;
        3: en = rise;
        default: en = 0;
      endcase
      if (wr && addr == 1) begin
        m_cnt = 0; m_div = 0;
      end else if (wr && addr == 0 && int'(wdata[4:0]) != m_cs * 8 + m_ps) begin
        m_div = 0;
      end else if (en) begin
        m_div++;
        if (m_div == (1 << m_ps)) begin
          m_div = 0;
          m_cnt = (m_cnt + 1) % 65536;
        end
      end
      if (wr && addr != 3) m_lat = 0;
      if (wr && addr == 0) begin
        m_cs = int'(wdata[4:3]); m_ps = int'(wdata[2:0]);
      end
      if (rd) begin
        if (addr == 1 || addr == 2) begin
          bit hi;
          hi = (addr == 1);
          if (!m_lat) begin
            m_buf = old_cnt; m_lat = 1; m_first_hi = hi;
          end else if (hi != m_first_hi) begin
            m_lat = 0;
          end
          m_rdata = hi ? (m_buf >> 8) & 8'hff : m_buf & 8'hff;
        end else if (addr == 0) begin
          m_rdata = m_cs * 8 + m_ps;
        end else begin
          m_rdata = 0;
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) check(cur_req, int'(rdata), m_rdata);
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // background source patterns
  always @(negedge clk) begin
    pat++;
    fix_en = fix_mode && ((pat % 3 == 0) || (pat % 7 == 0));
    if (ext_half > 0 && pat % ext_half == 0) ext_clk = ~ext_clk;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_rd(logic [1:0] a);
    @(negedge clk); rd = 1; wr = 0; addr = a;
    @(negedge clk); rd = 0;
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr = 1; rd = 0; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_pair_hi_first();
    bus_rd(2'd1); idle(3); bus_rd(2'd2);
  endtask

  task automatic rd_pair_lo_first();
    bus_rd(2'd2); idle(3); bus_rd(2'd1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    check("R1", int'(rdata), 0);
    bus_rd(2'd0); bus_rd(2'd1); bus_rd(2'd2);
    @(negedge clk);
    check("R1", int'(rdata), 0);

    // R2: coherency in both orders, repeated reads
    cur_req = "R2";
    bus_wr(2'd0, 8'h08);
    idle(20);
    rd_pair_lo_first();
    rd_pair_hi_first();
    bus_rd(2'd2); idle(5); bus_rd(2'd2); idle(5); bus_rd(2'd2); bus_rd(2'd1);
    bus_rd(2'd1); bus_rd(2'd1); idle(4); bus_rd(2'd2); bus_rd(2'd2);

    // R3: writes restart the buffer
    cur_req = "R3";
    bus_rd(2'd1); idle(6); bus_wr(2'd2, 8'h55); idle(3); bus_rd(2'd1); bus_rd(2'd2);
    bus_rd(2'd2); idle(6); bus_wr(2'd0, 8'h08); idle(3); bus_rd(2'd2); bus_rd(2'd1);
    bus_rd(2'd1); bus_wr(2'd3, 8'hff); idle(3); bus_rd(2'd1); bus_rd(2'd2);

    // R10: control read-back and unused address
    cur_req = "R10";
    bus_rd(2'd0); bus_rd(2'd3); idle(4); bus_rd(2'd0);

    // R4: high write clears, low write does not
    cur_req = "R4";
    idle(30); rd_pair_hi_first();
    bus_wr(2'd2, 8'h00); rd_pair_hi_first();
    bus_wr(2'd1, 8'h9a); rd_pair_lo_first();

    // R6: every prescale code on the bus clock
    cur_req = "R6";
    for (int p = 0; p < 8; p++) begin
      bus_wr(2'd0, 8'(8 | p));
      bus_wr(2'd1, 8'h00);
      idle(300);
      rd_pair_lo_first();
      bus_rd(2'd0);
    end

    // R5: fixed-rate enable source
    cur_req = "R5";
    fix_mode = 1;
    bus_wr(2'd0, 8'h11);
    for (int i = 0; i < 10; i++) begin idle(9); rd_pair_hi_first(); end
    fix_mode = 0;

    // R7: external pin, two rates
    cur_req = "R7";
    bus_wr(2'd0, 8'h18);
    ext_half = 2;
    for (int i = 0; i < 10; i++) begin idle(7); rd_pair_lo_first(); end
    ext_half = 5;
    bus_wr(2'd0, 8'h19);
    for (int i = 0; i < 10; i++) begin idle(13); rd_pair_hi_first(); end
    ext_half = 0;

    // R5: no clock selected holds the count
    cur_req = "R5";
    bus_wr(2'd0, 8'h00);
    rd_pair_hi_first(); idle(40); rd_pair_lo_first();

    // R8: prescaler cleared only on a changed setting
    cur_req = "R8";
    bus_wr(2'd0, 8'h0b);
    idle(5); bus_wr(2'd0, 8'h0b); idle(4); rd_pair_lo_first();
    idle(3); bus_wr(2'd0, 8'h0a); idle(3); rd_pair_lo_first();
    idle(2); bus_wr(2'd0, 8'h0b); idle(6); rd_pair_hi_first();
    idle(20); rd_pair_lo_first();

    // R9: wrap past 0xFFFF
    cur_req = "R9";
    bus_wr(2'd0, 8'h08);
    bus_wr(2'd1, 8'h00);
    idle(65520);
    for (int i = 0; i < 8; i++) begin idle(2); rd_pair_lo_first(); end

    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule